// File: doc/BRIEF.md
# Filter Gain and Cutoff Configuration Controller

This block produces the gain code and the lowpass cutoff code for a two-channel filter. Both channels always receive the same pair of codes. A mode input selects between two control paths. In pin mode, four configuration inputs set the codes directly. In serial mode, two of those inputs become an active-low chip select and a serial clock. A separate data input feeds an 8-bit shift register, and an 8-bit holding register takes the shifted byte when chip select rises.

The chip-select, serial-clock and data inputs are asynchronous to the block clock. They are oversampled through a synchronizer, and edges are found from the synchronized copies. The serial output shows the top bit of the shift register and changes only on serial-clock falling edges. While serial mode is active, that output is always driven. Because of this, several controllers can be chained: each output feeds the next device's data input, all devices share the clock and chip-select lines, and one chip-select rise loads every device together.

The holding register keeps only the two 2-bit fields that drive the outputs. Its reserved bits are discarded.

Top module: `fltcfg_ctl`

## Requirements
- R1: A synchronous reset clears the shift register, the held gain and cutoff fields, and the serial output to zero. In serial mode after reset, every gain and cutoff output reads 0.
- R2: While `pin_mode_i` is 1, the gain code is {`cfg_a_i`, `cfg_b_i`} and the cutoff code is {`cfg_c_ncs_i`, `cfg_d_sck_i`}. The codes follow the inputs within SYNC_STAGES+1 clock cycles.
- R3: In serial mode, while `cfg_c_ncs_i` is low, each rising edge of `cfg_d_sck_i` shifts `ser_din_i` into bit 0, so the first bit sent ends up in bit 7. A rising edge of `cfg_c_ncs_i` copies the byte into the holding register. The gain code is then bits [5:4] and the cutoff code is bits [3:2].
- R4: In serial mode, the gain and cutoff outputs do not change while bits are being shifted. They change only after chip select rises.
- R5: A serial-clock rising edge while chip select is high shifts nothing.
- R6: Each serial-clock falling edge while chip select is low sets `ser_dout_o` to bit 7 of the shift register. A bit sent into the device therefore reappears on `ser_dout_o` eight serial clocks later.
- R7: In serial mode, `ser_dout_en_o` is 1. In pin mode, it is 0. After chip select rises, `ser_dout_o` keeps its last value and is not cleared.
- R8: In pin mode, activity on the serial pins leaves the shift register and the holding register untouched. Returning to serial mode shows the codes held before.
- R9: When two devices are chained and 16 bits are sent, the device at the far end of the chain takes the first byte and the near device takes the second. Both take their bytes on the same chip-select rise.
- R10: Every channel's gain and cutoff output carries the same code.
- R11: Bits [7:6] and [1:0] of a written byte have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_mode_i | input | 1 | 1 selects pin mode, 0 selects serial mode |
| cfg_a_i | input | 1 | Gain code bit 1 in pin mode |
| cfg_b_i | input | 1 | Gain code bit 0 in pin mode (input side of the shared pin) |
| cfg_c_ncs_i | input | 1 | Cutoff code bit 1 in pin mode; active-low chip select in serial mode |
| cfg_d_sck_i | input | 1 | Cutoff code bit 0 in pin mode; serial clock in serial mode |
| ser_din_i | input | 1 | Serial data input |
| ser_dout_o | output | 1 | Serial data output (output side of the shared pin) |
| ser_dout_en_o | output | 1 | Drive enable for the shared pin, 1 in serial mode |
| ch_gain_o | output | NUM_CH*2 | Gain code per channel, channel 0 in the low bits |
| ch_cut_o | output | NUM_CH*2 | Cutoff code per channel, channel 0 in the low bits |

## Verification
Several properties are checked on every cycle:
- the reset clearing;
- the held fields changing only on a chip-select load, and then to the shifted byte's fields;
- the shift register staying still while chip select is high or pin mode is active;
- the serial output taking bit 7 on falling edges and holding otherwise;
- pin mode passing the synchronized pins through;
- all channels carrying identical codes.

Other behaviour shows only in the bench's scenarios, because it depends on a whole transfer:
- MSB-first ordering across the full byte;
- a byte reappearing on the serial output eight clocks later;
- a 16-bit write loading two chained devices on one chip-select rise;
- reserved bits having no effect;
- the held codes surviving a trip through pin mode.

// File: rtl/fc_pkg.sv
package fc_pkg;
   // width of each code field driven to the filter channels
   localparam int FIELD_W = 2;
   // synchronized pin vector layout
   localparam int SIG_W    = 6;
   localparam int IDX_DIN  = 0;
   localparam int IDX_SCK  = 1;
   localparam int IDX_NCS  = 2;
   localparam int IDX_B    = 3;
   localparam int IDX_A    = 4;
   localparam int IDX_MODE = 5;
   // chip select idles high, everything else low
   localparam logic [SIG_W-1:0] SYNC_RST = 6'b000100;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("fc_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      // inputs already synchronous to clk
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/fc_shift.sv
module fc_shift #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             out_en,
   input  logic             din,
   output logic [REG_W-1:0] sh_q,
   output logic             dout_q
);
   if (REG_W < 2) begin : g_bad_w
      $error("fc_shift: REG_W must be at least 2");
   end

   // MSB-first: new bit enters at bit 0, oldest bit sits at the top
   always_ff @(posedge clk) begin
      if (rst)           sh_q <= '0;
      else if (shift_en) sh_q <= {sh_q[REG_W-2:0], din};
   end

   // output stage updates only on the falling-edge strobe and holds otherwise
   always_ff @(posedge clk) begin
      if (rst)         dout_q <= 1'b0;
      else if (out_en) dout_q <= sh_q[REG_W-1];
   end
endmodule

// File: rtl/fc_latch.sv
module fc_latch #(
   parameter int FW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [FW-1:0] gain_d,
   input  logic [FW-1:0] cut_d,
   output logic [FW-1:0] gain_q,
   output logic [FW-1:0] cut_q
);
   // only the two live fields are held; reserved bits are never stored
   always_ff @(posedge clk) begin
      if (rst) begin
         gain_q <= '0;
         cut_q  <= '0;
      end else if (load) begin
         gain_q <= gain_d;
         cut_q  <= cut_d;
      end
   end
endmodule

// File: rtl/fltcfg_ctl.sv
module fltcfg_ctl
   import fc_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int GAIN_LSB    = 4,
   parameter int CUT_LSB     = 2,
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      pin_mode_i,
   input  logic                      cfg_a_i,
   input  logic                      cfg_b_i,
   input  logic                      cfg_c_ncs_i,
   input  logic                      cfg_d_sck_i,
   input  logic                      ser_din_i,
   output logic                      ser_dout_o,
   output logic                      ser_dout_en_o,
   output logic [NUM_CH*FIELD_W-1:0] ch_gain_o,
   output logic [NUM_CH*FIELD_W-1:0] ch_cut_o
);
   localparam int GAIN_MSB = GAIN_LSB + FIELD_W - 1;
   localparam int CUT_MSB  = CUT_LSB + FIELD_W - 1;

   // elaboration-time parameter checks
   if (GAIN_MSB >= REG_W || CUT_MSB >= REG_W) begin : g_bad_field
      $error("fltcfg_ctl: code field lies outside the register");
   end
   if (!(GAIN_LSB > CUT_MSB || CUT_LSB > GAIN_MSB)) begin : g_bad_overlap
      $error("fltcfg_ctl: gain and cutoff fields overlap");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("fltcfg_ctl: NUM_CH must be at least 1");
   end
   if (SYNC_STAGES == 1) begin : g_bad_sync
      $error("fltcfg_ctl: SYNC_STAGES must be 0 or at least 2");
   end

   // pin synchronization
   logic [SIG_W-1:0] raw_v, sync_v;
   assign raw_v[IDX_MODE] = pin_mode_i;
   assign raw_v[IDX_A]    = cfg_a_i;
   assign raw_v[IDX_B]    = cfg_b_i;
   assign raw_v[IDX_NCS]  = cfg_c_ncs_i;
   assign raw_v[IDX_SCK]  = cfg_d_sck_i;
   assign raw_v[IDX_DIN]  = ser_din_i;

   fc_sync #(.W(SIG_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_v),
      .q   (sync_v)
   );

   logic mode_s, a_s, b_s, ncs_s, sck_s, din_s;
   assign mode_s = sync_v[IDX_MODE];
   assign a_s    = sync_v[IDX_A];
   assign b_s    = sync_v[IDX_B];
   assign ncs_s  = sync_v[IDX_NCS];
   assign sck_s  = sync_v[IDX_SCK];
   assign din_s  = sync_v[IDX_DIN];

   // edge detection on synchronized chip select and serial clock
   logic ncs_d, sck_d;
   always_ff @(posedge clk) begin
      if (rst) begin
         ncs_d <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         ncs_d <= ncs_s;
         sck_d <= sck_s;
      end
   end

   logic sck_rise, sck_fall, ncs_rise, ser_act;
   logic shift_en, out_en, load;
   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign ncs_rise = ncs_s & ~ncs_d;
   assign ser_act  = ~mode_s;
   // shift clock is gated by chip select; the whole serial path is gated by mode
   assign shift_en = ser_act & ~ncs_s & sck_rise;
   assign out_en   = ser_act & ~ncs_s & sck_fall;
   assign load     = ser_act & ncs_rise;

   logic [REG_W-1:0] sh_q;
   fc_shift #(.REG_W(REG_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .out_en   (out_en),
      .din      (din_s),
      .sh_q     (sh_q),
      .dout_q   (ser_dout_o)
   );

   logic [FIELD_W-1:0] gain_q, cut_q;
   fc_latch #(.FW(FIELD_W)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .gain_d (sh_q[GAIN_LSB +: FIELD_W]),
      .cut_d  (sh_q[CUT_LSB +: FIELD_W]),
      .gain_q (gain_q),
      .cut_q  (cut_q)
   );

   // reserved bits reach only the output stage
   logic unused_rsv;
   assign unused_rsv = ^sh_q;

   // mode selection
   logic [FIELD_W-1:0] sel_gain, sel_cut;
   assign sel_gain      = mode_s ? {a_s, b_s}       : gain_q;
   assign sel_cut       = mode_s ? {ncs_s, sck_s}   : cut_q;
   assign ser_dout_en_o = ser_act;

   // identical codes fan out to every channel
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign ch_gain_o[ch*FIELD_W +: FIELD_W] = sel_gain;
      assign ch_cut_o[ch*FIELD_W +: FIELD_W]  = sel_cut;
   end
endmodule

// File: rtl/fc_ctl_chk.sv
module fc_ctl_chk
   import fc_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int GAIN_LSB = 4,
   parameter int CUT_LSB  = 2,
   parameter int NUM_CH   = 2
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      mode_s,
   input logic                      a_s,
   input logic                      b_s,
   input logic                      ncs_s,
   input logic                      sck_fall,
   input logic                      load,
   input logic [REG_W-1:0]          sh_q,
   input logic [FIELD_W-1:0]        gain_q,
   input logic [FIELD_W-1:0]        cut_q,
   input logic                      ser_dout_o,
   input logic [NUM_CH*FIELD_W-1:0] ch_gain_o,
   input logic [NUM_CH*FIELD_W-1:0] ch_cut_o
);
   AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (sh_q == '0 && gain_q == '0 && cut_q == '0 && ser_dout_o == 1'b0)); // R1

   AST_PIN_PASS: assert property (@(posedge clk) disable iff (rst)
      mode_s |-> ch_gain_o[FIELD_W-1:0] == {a_s, b_s}); // R2

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
      load |=> (gain_q == $past(sh_q[GAIN_LSB +: FIELD_W]) &&
                cut_q  == $past(sh_q[CUT_LSB +: FIELD_W]))); // R3

   AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(gain_q) && $stable(cut_q))); // R4

   AST_NO_SHIFT_DESEL: assert property (@(posedge clk) disable iff (rst)
      ncs_s |=> $stable(sh_q)); // R5

   AST_DOUT_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
      (!mode_s && !ncs_s && sck_fall) |=> ser_dout_o == $past(sh_q[REG_W-1])); // R6

   AST_DOUT_KEEP: assert property (@(posedge clk) disable iff (rst)
      ncs_s |=> $stable(ser_dout_o)); // R7

   AST_PIN_BYPASS: assert property (@(posedge clk) disable iff (rst)
      mode_s |=> ($stable(sh_q) && $stable(gain_q) && $stable(cut_q))); // R8

   AST_CH_MATCH: assert property (@(posedge clk) disable iff (rst)
      (ch_gain_o == {NUM_CH{ch_gain_o[FIELD_W-1:0]}} &&
       ch_cut_o  == {NUM_CH{ch_cut_o[FIELD_W-1:0]}})); // R10
endmodule

bind fltcfg_ctl fc_ctl_chk #(
   .REG_W    (REG_W),
   .GAIN_LSB (GAIN_LSB),
   .CUT_LSB  (CUT_LSB),
   .NUM_CH   (NUM_CH)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mode_s     (mode_s),
   .a_s        (a_s),
   .b_s        (b_s),
   .ncs_s      (ncs_s),
   .sck_fall   (sck_fall),
   .load       (load),
   .sh_q       (sh_q),
   .gain_q     (gain_q),
   .cut_q      (cut_q),
   .ser_dout_o (ser_dout_o),
   .ch_gain_o  (ch_gain_o),
   .ch_cut_o   (ch_cut_o)
);

// File: tb/fltcfg_ctl_test.sv
module fltcfg_ctl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 2;
   localparam int HALF       = 8;   // block clocks per serial half period

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode = 1'b0, ga = 1'b0, gb = 1'b0, ncs = 1'b1, sck = 1'b0, din = 1'b0;
   logic sdo_a, oe_a, sdo_b, oe_b;
   logic [NCH*2-1:0] chg_a, chc_a, chg_b, chc_b;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   logic [15:0] hist = '0;      // model of the 16-bit chain contents
   logic [7:0]  exp_a = '0;     // model of near device held byte
   logic [7:0]  exp_b = '0;     // model of far device held byte

   always #(CLK_PERIOD/2) clk = ~clk;

   fltcfg_ctl #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst(rst), .pin_mode_i(mode), .cfg_a_i(ga), .cfg_b_i(gb),
      .cfg_c_ncs_i(ncs), .cfg_d_sck_i(sck), .ser_din_i(din),
      .ser_dout_o(sdo_a), .ser_dout_en_o(oe_a), .ch_gain_o(chg_a), .ch_cut_o(chc_a));

   fltcfg_ctl #(.NUM_CH(NCH)) uut_b (
      .clk(clk), .rst(rst), .pin_mode_i(mode), .cfg_a_i(ga), .cfg_b_i(gb),
      .cfg_c_ncs_i(ncs), .cfg_d_sck_i(sck), .ser_din_i(sdo_a),
      .ser_dout_o(sdo_b), .ser_dout_en_o(oe_b), .ch_gain_o(chg_b), .ch_cut_o(chc_b));

   function automatic logic [NCH*2-1:0] f_gain(input logic [7:0] b);
      return {NCH{b[5:4]}};
   endfunction
   function automatic logic [NCH*2-1:0] f_cut(input logic [7:0] b);
      return {NCH{b[3:2]}};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_serial_outs(input string tag);
      chk({tag, " near gain"}, chg_a, f_gain(exp_a));
      chk({tag, " near cut"},  chc_a, f_cut(exp_a));
      chk({tag, " far gain"},  chg_b, f_gain(exp_b));
      chk({tag, " far cut"},   chc_b, f_cut(exp_b));
   endtask

   // send n bits MSB-first with chip select low, then raise chip select
   task automatic xfer(input int n, input logic [15:0] data, input string tag);
      ncs = 1'b0;
      wait_clk(HALF);
      for (int i = n - 1; i >= 0; i--) begin
         din = data[i];
         wait_clk(HALF);
         sck  = 1'b1;
         hist = {hist[14:0], data[i]};
         wait_clk(HALF);
         sck = 1'b0;
         wait_clk(HALF);
         chk("R6 sdo top bit", sdo_a, hist[7]);
         chk("R6 chained sdo", sdo_b, hist[15]);
         if (i == n / 2) chk_serial_outs("R4 hold during shift");
      end
      ncs = 1'b1;
      wait_clk(HALF);
      exp_a = hist[7:0];
      exp_b = hist[15:8];
      chk_serial_outs(tag);
      chk("R7 sdo kept after select rise", sdo_a, hist[7]);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] b0, b1;
      logic [3:0] p;
      void'($urandom(32'd6603));

      // reset
      wait_clk(5);
      rst = 1'b0;
      wait_clk(6);
      chk_serial_outs("R1 reset outputs");
      chk("R1 reset sdo", sdo_a, 1'b0);
      chk("R7 enable in serial mode", oe_a, 1'b1);
      chk("R10 channels equal after reset", chg_a, {NCH{chg_a[1:0]}});

      // single-device directed write
      xfer(8, 16'h0024, "R3 write 0x24");
      chk("R3 near gain=2", chg_a[1:0], 2'd2);
      chk("R3 near cut=1",  chc_a[1:0], 2'd1);

      // reserved bits ignored
      xfer(8, 16'h00DB, "R11 reserved set");
      chk("R11 gain with reserved set", chg_a[1:0], 2'd1);
      chk("R11 cut with reserved set",  chc_a[1:0], 2'd2);
      xfer(8, 16'h0018, "R11 reserved clear");
      chk("R11 gain with reserved clear", chg_a[1:0], 2'd1);

      // clock pulses with chip select high: no shift, sdo held
      din = 1'b1;
      for (int k = 0; k < 3; k++) begin
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
      wait_clk(HALF);
      chk("R7 sdo held while deselected", sdo_a, hist[7]);
      chk_serial_outs("R5 no load while deselected");
      xfer(8, 16'h0030, "R5 clean byte after gated pulses");

      // two-device chain
      xfer(16, 16'h2418, "R9 chain");
      chk("R9 far gain", chg_b[1:0], 2'd2);
      chk("R9 near gain", chg_a[1:0], 2'd1);

      // random single writes
      for (int it = 0; it < 20; it++) begin
         b0 = 8'($urandom);
         xfer(8, {8'h00, b0}, "R3 random write");
         chk("R10 channels equal", chc_a, {NCH{chc_a[1:0]}});
      end

      // random chained writes
      for (int it = 0; it < 6; it++) begin
         b0 = 8'($urandom);
         b1 = 8'($urandom);
         xfer(16, {b0, b1}, "R9 random chain");
      end

      // pin mode
      mode = 1'b1;
      wait_clk(6);
      chk("R7 enable off in pin mode", oe_a, 1'b0);
      for (int it = 0; it < 12; it++) begin
         p = 4'($urandom);
         {ga, gb, ncs, sck} = p;
         wait_clk(6);
         chk("R2 pin gain", chg_a, {NCH{p[3:2]}});
         chk("R2 pin cut",  chc_a, {NCH{p[1:0]}});
         chk("R10 pin channels", chg_b, {NCH{p[3:2]}});
      end
      ncs = 1'b1;
      sck = 1'b0;
      wait_clk(6);
      mode = 1'b0;
      wait_clk(6);
      chk_serial_outs("R8 held codes after pin mode");
      xfer(8, 16'h0014, "R8 shift register untouched");

      // reset after activity
      rst = 1'b1;
      wait_clk(3);
      rst = 1'b0;
      wait_clk(6);
      hist  = '0;
      exp_a = '0;
      exp_b = '0;
      chk_serial_outs("R1 reset after writes");
      chk("R1 sdo cleared", sdo_a, 1'b0);
      xfer(8, 16'h002C, "R1 write after reset");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule